// File: doc/BRIEF.md
# Cartridge Bank Mapper with Sound Register Window

This block sits between a 16-bit CPU address bus and an external memory. It splits the CPU space into four 8 KB pages. Each page is backed by a bank register whose value becomes the upper part of the external address. The page index is address bits [14:13] XOR 2. The external address is the selected bank value joined above CPU address bits [12:0].

The block also decodes a window of sound-generator registers. That window is live only while a bank register holds a key value. In legacy mode the key is bank 2 bits [5:0] all ones, and the window sits at 0x9800–0x9FFF. A configuration word near the top of 0xB800–0xBFFF can select an enhanced mode. In that mode the key is bank 3 bit 7, and the window moves to 0xB800–0xBFFF. The same word turns individual pages into write-through RAM pages.

The sound registers themselves live outside this block. It issues read and write chip selects, passes on the low 8 address bits, and flags which window layout is active. Every output is registered, so a CPU strobe sampled on one clock edge shows at the ports until the next edge.

Top module: `bankmap_top`

## Requirements
- R1: A synchronous reset loads bank registers 0..3 with 0, 1, 2 and 3. It clears the sound-enable flag, enhanced mode and all RAM enables, and it holds every output strobe low.
- R2: For any forwarded access, mem_addr = {bank[idx], cpu_addr[12:0]} with idx = cpu_addr[14:13] XOR 2, using the bank values in effect before the access.
- R3: A write with cpu_addr[15:11] equal to 01010, 01110, 10010 or 10110 (0x5000, 0x7000, 0x9000 or 0xB000, each 2 KB long) loads bank register 0, 1, 2 or 3. A write elsewhere, such as 0x5800, loads no bank register.
- R4: In legacy mode, while sound is enabled, reads and writes in 0x9800–0x9FFF raise snd_rd or snd_wr with snd_enh=0 and snd_addr = cpu_addr[7:0]. Sound is enabled when bank 2 bits [5:0] are all ones; bits [7:6] are ignored.
- R5: In enhanced mode, sound is enabled when bank 3 bit 7 is set. The window is then 0xB800–0xBFFF, with snd_enh=1, and 0x9800–0x9FFF reads go to memory.
- R6: A write to 0xB800–0xBFFF with cpu_addr[10:1] all ones (0xBFFE, 0xBFFF) is the configuration word. Bit 5 selects enhanced mode. Bit 4 enables RAM on all pages. Bits 0, 1 and 2 enable RAM on pages 0, 1 and 2. No other address in that range reaches the configuration word, and a configuration write never raises snd_wr. In enhanced mode a read of 0xBFFE or 0xBFFF is a sound read.
- R7: A write to a RAM-enabled page raises mem_we with mem_wdata = cpu_wdata. Bank-register loads and sound writes through that page are suppressed. Reads are not affected.
- R8: The sound-enable flag is re-evaluated, using the new values, only when a bank value or the mode bit actually changes. Rewriting an unchanged value leaves the flag as it is.
- R9: A read that misses the active sound window raises mem_rd. A write to a page without RAM raises no mem_we.
- R10: Each strobe is a single-cycle pulse, one cycle after the CPU strobe. At most one of mem_rd, mem_we, snd_rd and snd_wr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| mem_addr | output | 21 | Mapped external memory address |
| mem_wdata | output | 8 | Data for external memory writes |
| mem_rd | output | 1 | External memory read strobe |
| mem_we | output | 1 | External memory write enable |
| snd_addr | output | 8 | Sound register offset (CPU address bits [7:0]) |
| snd_wdata | output | 8 | Data for sound register writes |
| snd_rd | output | 1 | Sound register read select |
| snd_wr | output | 1 | Sound register write select |
| snd_enh | output | 1 | High when the enhanced window layout is active |

## Verification
The bound checker watches properties that hold in every cycle. It checks that the strobes are exclusive pulses, each traced to a CPU strobe one cycle earlier. It checks that the page offset passes through unchanged, that each sound select falls in the window matching snd_enh with the right register offset, and that the outputs are quiet after reset. Which bank a page maps to, when the sound key opens or closes the window, and how RAM pages swallow bank and sound writes all depend on stored state. Only the bench's directed scenarios can show these, by comparing every access against a behavioural model of the bank registers, mode, RAM enables and sound flag.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  // address classes seen by the mapper
  typedef enum logic [2:0] {
    RGN_MEM,
    RGN_BANKSEL,
    RGN_SND_LEG,
    RGN_SND_ENH,
    RGN_CFG
  } rgn_e;

  // upper five address bits select a 2 KB slot
  localparam int          SLOT_W      = 5;
  localparam logic [4:0]  SLOT_B0     = 5'b01010;
  localparam logic [4:0]  SLOT_B1     = 5'b01110;
  localparam logic [4:0]  SLOT_B2     = 5'b10010;
  localparam logic [4:0]  SLOT_B3     = 5'b10110;
  localparam logic [4:0]  SLOT_LEG    = 5'b10011;
  localparam logic [4:0]  SLOT_ENH    = 5'b10111;

  // configuration word fields
  localparam int          CFG_ALL_BIT = 4;
  localparam int          CFG_ENH_BIT = 5;

  // sound key location
  localparam int          LEG_BANK    = 2;
  localparam int          ENH_BANK    = 3;
  localparam int          LEG_KEY_W   = 6;
  localparam int          ENH_KEY_BIT = 7;

  // page index flip
  localparam logic [1:0]  IDX_FLIP    = 2'b10;

endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 13,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:1] hi_addr,
  output rgn_e              rgn,
  output logic [IDX_W-1:0]  idx
);

  localparam int SLOT_LSB = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0] slot;
  logic              cfg_hit;

  assign slot    = hi_addr[ADDR_W-1:SLOT_LSB];
  assign cfg_hit = &hi_addr[SLOT_LSB-1:1];
  assign idx     = hi_addr[PAGE_W+IDX_W-1:PAGE_W] ^ IDX_W'(IDX_FLIP);

  always_comb begin
    case (slot)
      SLOT_B0, SLOT_B1, SLOT_B2, SLOT_B3: rgn = RGN_BANKSEL;
      SLOT_LEG:                           rgn = RGN_SND_LEG;
      SLOT_ENH:                           rgn = cfg_hit ? RGN_CFG : RGN_SND_ENH;
      default:                            rgn = RGN_MEM;
    endcase
  end

endmodule

// File: rtl/bankmap_banks.sv
module bankmap_banks #(
  parameter int NBANK  = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NBANK-1:0][DATA_W-1:0]  bank_q,
  output logic [NBANK-1:0][DATA_W-1:0]  bank_d,
  output logic                          changed
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_d[g] = (wr_en && (wr_idx == IDX_W'(g))) ? wr_data : bank_q[g];

    always_ff @(posedge clk) begin
      if (rst) bank_q[g] <= DATA_W'(g);
      else     bank_q[g] <= bank_d[g];
    end
  end

  assign changed = (bank_d != bank_q);

endmodule

// File: rtl/bankmap_cfg.sv
module bankmap_cfg #(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NBANK-2:0] ram_bits,
  input  logic             all_bit,
  input  logic             enh_bit,
  output logic [NBANK-1:0] ram_en,
  output logic             enh_q,
  output logic             enh_d,
  output logic             mode_changed
);

  logic [NBANK-1:0] ram_nxt;

  // pages below the last have their own bit; the last follows the global bit only
  for (genvar g = 0; g < NBANK; g++) begin : g_ram
    if (g < NBANK - 1) begin : g_own
      assign ram_nxt[g] = all_bit | ram_bits[g];
    end else begin : g_glob
      assign ram_nxt[g] = all_bit;
    end
  end

  assign enh_d        = wr_en ? enh_bit : enh_q;
  assign mode_changed = enh_d ^ enh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en <= '0;
      enh_q  <= 1'b0;
    end else begin
      if (wr_en) ram_en <= ram_nxt;
      enh_q <= enh_d;
    end
  end

endmodule

// File: rtl/bankmap_sndgate.sv
module bankmap_sndgate #(
  parameter int KEY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             enh_d,
  input  logic [KEY_W-1:0] leg_key,
  input  logic             enh_key,
  output logic             snd_en
);

  always_ff @(posedge clk) begin
    if (rst)      snd_en <= 1'b0;
    else if (upd) snd_en <= enh_d ? enh_key : (&leg_key);
  end

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 13,
  parameter int NBANK  = 4,
  parameter int SND_W  = 8,
  localparam int IDX_W = $clog2(NBANK),
  localparam int EXT_W = DATA_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [EXT_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [SND_W-1:0]  snd_addr,
  output logic [DATA_W-1:0] snd_wdata,
  output logic              snd_rd,
  output logic              snd_wr,
  output logic              snd_enh
);

  rgn_e                         rgn;
  logic [IDX_W-1:0]             idx;
  logic [NBANK-1:0][DATA_W-1:0] bank_q;
  logic [NBANK-1:0][DATA_W-1:0] bank_d;
  logic                         bank_chg;
  logic [NBANK-1:0]             ram_en;
  logic                         enh_q;
  logic                         enh_d;
  logic                         mode_chg;
  logic                         snd_en;

  logic page_ram;
  logic bank_wr;
  logic cfg_wr;
  logic leg_hit;
  logic enh_hit;
  logic snd_rd_hit;
  logic snd_wr_hit;

  bankmap_decode #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .IDX_W  (IDX_W)
  ) u_decode (
    .hi_addr (cpu_addr[ADDR_W-1:1]),
    .rgn     (rgn),
    .idx     (idx)
  );

  assign page_ram = ram_en[idx];
  assign bank_wr  = cpu_wr && (rgn == RGN_BANKSEL) && !page_ram;
  assign cfg_wr   = cpu_wr && (rgn == RGN_CFG);

  bankmap_banks #(
    .NBANK  (NBANK),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_banks (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_wr),
    .wr_idx  (idx),
    .wr_data (cpu_wdata),
    .bank_q  (bank_q),
    .bank_d  (bank_d),
    .changed (bank_chg)
  );

  bankmap_cfg #(
    .NBANK (NBANK)
  ) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (cfg_wr),
    .ram_bits     (cpu_wdata[NBANK-2:0]),
    .all_bit      (cpu_wdata[CFG_ALL_BIT]),
    .enh_bit      (cpu_wdata[CFG_ENH_BIT]),
    .ram_en       (ram_en),
    .enh_q        (enh_q),
    .enh_d        (enh_d),
    .mode_changed (mode_chg)
  );

  bankmap_sndgate #(
    .KEY_W (LEG_KEY_W)
  ) u_sndgate (
    .clk     (clk),
    .rst     (rst),
    .upd     (bank_chg || mode_chg),
    .enh_d   (enh_d),
    .leg_key (bank_d[LEG_BANK][LEG_KEY_W-1:0]),
    .enh_key (bank_d[ENH_BANK][ENH_KEY_BIT]),
    .snd_en  (snd_en)
  );

  // window hits use the state in force before this access
  assign leg_hit    = snd_en && !enh_q && (rgn == RGN_SND_LEG);
  assign enh_hit    = snd_en &&  enh_q && (rgn == RGN_SND_ENH);
  assign snd_rd_hit = leg_hit || enh_hit || (snd_en && enh_q && (rgn == RGN_CFG));
  assign snd_wr_hit = (leg_hit || enh_hit) && !page_ram;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      snd_addr  <= '0;
      snd_wdata <= '0;
      snd_rd    <= 1'b0;
      snd_wr    <= 1'b0;
      snd_enh   <= 1'b0;
    end else begin
      mem_addr  <= {bank_q[idx], cpu_addr[PAGE_W-1:0]};
      mem_wdata <= cpu_wdata;
      mem_rd    <= cpu_rd && !cpu_wr && !snd_rd_hit;
      mem_we    <= cpu_wr && page_ram;
      snd_addr  <= cpu_addr[SND_W-1:0];
      snd_wdata <= cpu_wdata;
      snd_rd    <= cpu_rd && !cpu_wr && snd_rd_hit;
      snd_wr    <= cpu_wr && snd_wr_hit;
      snd_enh   <= enh_q;
    end
  end

endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 13,
  parameter int SND_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [PAGE_W-1:0] mem_off,
  input logic              mem_rd,
  input logic              mem_we,
  input logic [SND_W-1:0]  snd_addr,
  input logic              snd_rd,
  input logic              snd_wr,
  input logic              snd_enh
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $fell(rst) |-> !(mem_rd || mem_we || snd_rd || snd_wr));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_we, snd_rd, snd_wr}));

  // R10
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || snd_rd) |-> $past(cpu_rd));

  // R10
  wr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || snd_wr) |-> $past(cpu_wr));

  // R2
  page_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_we) |-> (mem_off == $past(cpu_addr[PAGE_W-1:0])));

  // R4
  leg_win_chk: assert property (@(posedge clk) disable iff (rst)
    ((snd_rd || snd_wr) && !snd_enh) |->
      (($past(cpu_addr[ADDR_W-1:ADDR_W-SLOT_W]) == SLOT_LEG) &&
       (snd_addr == $past(cpu_addr[SND_W-1:0]))));

  // R5
  enh_win_chk: assert property (@(posedge clk) disable iff (rst)
    ((snd_rd || snd_wr) && snd_enh) |->
      (($past(cpu_addr[ADDR_W-1:ADDR_W-SLOT_W]) == SLOT_ENH) &&
       (snd_addr == $past(cpu_addr[SND_W-1:0]))));

  // R6
  cfg_no_snd_chk: assert property (@(posedge clk) disable iff (rst)
    snd_wr |-> !(&$past(cpu_addr[ADDR_W-SLOT_W-1:1]) &&
                 ($past(cpu_addr[ADDR_W-1:ADDR_W-SLOT_W]) == SLOT_ENH)));

endmodule

bind bankmap_top bankmap_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W),
  .SND_W  (SND_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cpu_rd   (cpu_rd),
  .cpu_wr   (cpu_wr),
  .mem_off  (mem_addr[PAGE_W-1:0]),
  .mem_rd   (mem_rd),
  .mem_we   (mem_we),
  .snd_addr (snd_addr),
  .snd_rd   (snd_rd),
  .snd_wr   (snd_wr),
  .snd_enh  (snd_enh)
);

// File: tb/test_bankmap_top.sv
module test_bankmap_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [20:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rd;
  logic        mem_we;
  logic [7:0]  snd_addr;
  logic [7:0]  snd_wdata;
  logic        snd_rd;
  logic        snd_wr;
  logic        snd_enh;

  int checks   = 0;
  int failures = 0;

  // behavioural model state
  logic [7:0] m_bank [4];
  logic [3:0] m_ram;
  logic       m_enh;
  logic       m_sen;

  always #10 clk = ~clk;

  bankmap_top i_bankmap_top (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .snd_addr  (snd_addr),
    .snd_wdata (snd_wdata),
    .snd_rd    (snd_rd),
    .snd_wr    (snd_wr),
    .snd_enh   (snd_enh)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_bank[i] = 8'(i);
    m_ram = '0;
    m_enh = 1'b0;
    m_sen = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one CPU access; entered and left at a falling edge
  task automatic access(input string req, input bit wr,
                        input logic [15:0] a, input logic [7:0] d);
    logic [1:0]  idx;
    logic [4:0]  slot;
    logic        cfg;
    logic [20:0] ea;
    logic        e_mrd, e_mwe, e_srd, e_swr, hit, chg;
    logic [7:0]  nb;
    idx  = a[14:13] ^ 2'b10;
    slot = a[15:11];
    cfg  = (slot == 5'b10111) && (&a[10:1]);
    ea   = {m_bank[idx], a[12:0]};
    e_mrd = 0; e_mwe = 0; e_srd = 0; e_swr = 0;
    if (wr) begin
      e_mwe = m_ram[idx];
      e_swr = !m_ram[idx] && m_sen &&
              ((slot == 5'b10011 && !m_enh) || (slot == 5'b10111 && !cfg && m_enh));
    end else begin
      hit   = m_sen && ((slot == 5'b10011 && !m_enh) || (slot == 5'b10111 && m_enh));
      e_srd = hit;
      e_mrd = !hit;
    end
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_rd    = !wr;
    cpu_wr    = wr;
    @(negedge clk);
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    check(req, "mem_rd", 32'(mem_rd), 32'(e_mrd));
    check(req, "mem_we", 32'(mem_we), 32'(e_mwe));
    check(req, "snd_rd", 32'(snd_rd), 32'(e_srd));
    check(req, "snd_wr", 32'(snd_wr), 32'(e_swr));
    if (e_mrd || e_mwe) check(req, "mem_addr", 32'(mem_addr), 32'(ea));
    if (e_mwe)          check(req, "mem_wdata", 32'(mem_wdata), 32'(d));
    if (e_srd || e_swr) begin
      check(req, "snd_addr", 32'(snd_addr), 32'(a[7:0]));
      check(req, "snd_enh", 32'(snd_enh), 32'(m_enh));
    end
    if (e_swr) check(req, "snd_wdata", 32'(snd_wdata), 32'(d));
    // model update
    if (wr) begin
      chg = 1'b0;
      if ((slot == 5'b01010 || slot == 5'b01110 || slot == 5'b10010 || slot == 5'b10110)
          && !m_ram[idx]) begin
        nb = d;
        chg = (m_bank[idx] != nb);
        m_bank[idx] = nb;
      end
      if (cfg) begin
        m_ram[0] = d[4] | d[0];
        m_ram[1] = d[4] | d[1];
        m_ram[2] = d[4] | d[2];
        m_ram[3] = d[4];
        if (m_enh != d[5]) chg = 1'b1;
        m_enh = d[5];
      end
      if (chg) m_sen = m_enh ? m_bank[3][7] : (&m_bank[2][5:0]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "strobes in reset", 32'({mem_rd, mem_we, snd_rd, snd_wr}), 32'h0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1", "strobes after reset", 32'({mem_rd, mem_we, snd_rd, snd_wr}), 32'h0);
    access("R1", 0, 16'h4000, 8'h00);
    access("R1", 0, 16'h9800, 8'h00);
    access("R1", 0, 16'hB800, 8'h00);
  endtask

  task automatic t_map();
    do_reset();
    access("R2", 0, 16'h0123, 8'h00);
    access("R2", 0, 16'h6ABC, 8'h00);
    access("R2", 0, 16'h8001, 8'h00);
    access("R2", 0, 16'hA7FF, 8'h00);
    access("R9", 0, 16'hFFFF, 8'h00);
  endtask

  task automatic t_banksel();
    do_reset();
    access("R3", 1, 16'h5000, 8'h11);
    access("R3", 1, 16'h77FF, 8'h22);
    access("R3", 1, 16'h9400, 8'h33);
    access("R3", 1, 16'hB7FF, 8'h44);
    access("R3", 1, 16'h5800, 8'h99);
    access("R3", 0, 16'h4010, 8'h00);
    access("R3", 0, 16'h6010, 8'h00);
    access("R3", 0, 16'h8010, 8'h00);
    access("R3", 0, 16'hA010, 8'h00);
    access("R9", 1, 16'h4444, 8'h12);
  endtask

  task automatic t_legacy();
    do_reset();
    access("R4", 1, 16'h9000, 8'h3F);
    access("R4", 1, 16'h9880, 8'h5A);
    access("R4", 0, 16'h98AA, 8'h00);
    access("R4", 0, 16'h9FFF, 8'h00);
    access("R4", 0, 16'h97FF, 8'h00);
    access("R4", 1, 16'h9000, 8'h7E);
    access("R4", 0, 16'h9800, 8'h00);
    access("R4", 1, 16'h9800, 8'h01);
    access("R4", 1, 16'h9000, 8'hFF);
    access("R4", 0, 16'h9801, 8'h00);
    access("R4", 0, 16'hB800, 8'h00);
  endtask

  task automatic t_enhanced();
    do_reset();
    access("R6", 1, 16'hBFFE, 8'h20);
    access("R5", 1, 16'hB000, 8'h80);
    access("R5", 1, 16'hB810, 8'hC3);
    access("R5", 0, 16'hB8FF, 8'h00);
    access("R6", 0, 16'hBFFE, 8'h00);
    access("R5", 0, 16'h9800, 8'h00);
    access("R5", 1, 16'h9000, 8'h3F);
    access("R5", 0, 16'h9800, 8'h00);
    access("R5", 1, 16'hB000, 8'h7F);
    access("R5", 0, 16'hB800, 8'h00);
  endtask

  task automatic t_cfg_addr();
    do_reset();
    access("R6", 1, 16'hBFFF, 8'h20);
    access("R6", 1, 16'hB000, 8'h80);
    access("R6", 1, 16'hBFFC, 8'h11);
    access("R6", 1, 16'hBFFE, 8'h00);
    access("R6", 0, 16'h9800, 8'h00);
    access("R6", 0, 16'hB800, 8'h00);
    access("R6", 1, 16'hBBFE, 8'h20);
    access("R6", 0, 16'hB800, 8'h00);
    access("R6", 1, 16'h4000, 8'h01);
  endtask

  task automatic t_ram();
    do_reset();
    access("R7", 1, 16'hBFFE, 8'h01);
    access("R7", 1, 16'h5000, 8'h55);
    access("R7", 0, 16'h4000, 8'h00);
    access("R7", 1, 16'h4123, 8'h99);
    access("R7", 1, 16'h7000, 8'h21);
    access("R7", 0, 16'h6000, 8'h00);
    access("R7", 1, 16'hBFFE, 8'h10);
    access("R7", 1, 16'h9000, 8'h3F);
    access("R7", 0, 16'h9800, 8'h00);
    access("R7", 1, 16'hA000, 8'h77);
    do_reset();
    access("R7", 1, 16'h9000, 8'h3F);
    access("R7", 1, 16'hBFFE, 8'h04);
    access("R7", 1, 16'h9880, 8'h66);
    access("R7", 0, 16'h9880, 8'h00);
    access("R7", 1, 16'h6000, 8'h01);
  endtask

  task automatic t_keep();
    do_reset();
    access("R8", 1, 16'h9000, 8'h3F);
    access("R8", 1, 16'h9000, 8'h3F);
    access("R8", 0, 16'h9800, 8'h00);
    access("R8", 1, 16'hBFFE, 8'h00);
    access("R8", 0, 16'h9800, 8'h00);
    access("R8", 1, 16'hB000, 8'h80);
    access("R8", 0, 16'h9800, 8'h00);
    access("R8", 1, 16'hBFFE, 8'h20);
    access("R8", 0, 16'hB800, 8'h00);
    access("R8", 1, 16'hBFFF, 8'h20);
    access("R8", 0, 16'hB801, 8'h00);
  endtask

  task automatic t_pulse();
    do_reset();
    access("R10", 0, 16'h4000, 8'h00);
    @(negedge clk);
    check("R10", "idle after read", 32'({mem_rd, mem_we, snd_rd, snd_wr}), 32'h0);
    access("R10", 1, 16'h9000, 8'h3F);
    access("R10", 1, 16'h9810, 8'h01);
    @(negedge clk);
    check("R10", "idle after sound write", 32'({mem_rd, mem_we, snd_rd, snd_wr}), 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    model_reset();
    t_reset();
    t_map();
    t_banksel();
    t_legacy();
    t_enhanced();
    t_cfg_addr();
    t_ram();
    t_keep();
    t_pulse();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule